// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block takes stereo PCM audio from a three-wire serial link (bit clock, frame clock and serial data) and turns it into a pair of parallel 24-bit samples. The serial clocks are slow compared with the system clock. They are brought into the system clock domain through synchronizer stages and reduced to single-cycle sampling events. Every stream is sent MSB first in two's-complement form, and in each frame the left word is sent before the right word.

A 2-bit format input picks one of four framing conventions. These are right-justified, I2S, left-justified and a DSP-style mode in which a short frame-clock pulse marks each channel. In right-justified mode a 2-bit length input picks 16, 20 or 24 bits. A packed option supports frames of 32 bit clocks, in which each word fills its whole half-frame. A word closes when the next channel starts. Once a right word has closed after a left word, the two are presented together with a one-cycle strobe.

Top module: `stereo_serial_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, `valid_o` is 0 and both sample outputs are 0.
- R2: With `fmt_i`=2 (left-justified), frame clock high means left and low means right. The MSB is the bit sampled at the first rising bit-clock edge after a frame-clock change. A frame of exactly twice the word length is received intact.
- R3: With `fmt_i`=1 (I2S), frame clock low means left and high means right. The MSB is sampled one bit clock after the frame-clock change, and the last bit of a word may share its bit-clock period with the next channel's frame-clock level.
- R4: With `fmt_i`=0 (right-justified) and `packed_i`=0, capture starts at zero-based bit-clock position 8, 12 or 16 after the frame-clock change, for `wlen_i` = 0 (24 bits), 1 (20 bits) or 2 (16 bits) respectively. `wlen_i`=3 also means 24 bits. Bits at earlier positions have no effect on the output.
- R5: The right-justified start positions do not depend on the number of bit clocks per frame. A 96-clock frame uses the same positions as a 64-clock frame.
- R6: With `fmt_i`=3 (DSP), data is sampled on the falling bit-clock edge. A frame-clock rise starts a channel, and its data begins at the first sample taken with the frame clock low. The first pulse after reset starts a left word, and left and right alternate from then on.
- R7: Outside right-justified mode, bits past the 24th bit of a word are dropped. The output keeps the first 24 bits received.
- R8: A word shorter than 24 bits is left-aligned in its 24-bit output, and the unused low bits are 0.
- R9: With `packed_i`=1 and right-justified format selected, a frame has 32 bit clocks. Each 16-bit word starts at the frame-clock change and fills its half-frame.
- R10: `valid_o` is a one-cycle pulse that comes once the right word of a frame has closed. `left_o` and `right_o` change only in the cycle in which `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial clocks |
| rst | input | 1 | Synchronous active-high reset |
| bclk_i | input | 1 | Serial bit clock |
| fclk_i | input | 1 | Left/right frame clock |
| sdata_i | input | 1 | Serial data, MSB first |
| fmt_i | input | 2 | 0 right-justified, 1 I2S, 2 left-justified, 3 DSP |
| wlen_i | input | 2 | Right-justified length: 0 = 24, 1 = 20, 2 = 16, 3 = 24 bits |
| packed_i | input | 1 | 32-clock packed frames |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
On every cycle, the assertions check that the strobe lasts one cycle, that the sample outputs stay still outside the strobe, that reset silences the strobe, and that 16-bit right-justified words carry a zero low byte. Only the bench scenarios can show that the correct bits reach the outputs. This covers where the MSB falls in each format, the channel polarity, the fixed right-justified offsets in a long frame, truncation of long words, and alternation of DSP channels from the first pulse.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int WORD_W = 24;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef enum logic [1:0] {
        FMT_RJ  = 2'd0,
        FMT_I2S = 2'd1,
        FMT_LJ  = 2'd2,
        FMT_DSP = 2'd3
    } fmt_e;

    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    // Synchronized serial lines plus edge events of the bit clock
    typedef struct packed {
        logic rise;
        logic fall;
        logic fclk;
        logic sdata;
    } serial_evt_t;

    // Per-sample decision from the framer to the assembler
    typedef struct packed {
        logic             bnd;
        chan_e            new_ch;
        logic             cap;
        logic             dbit;
        logic [CNT_W-1:0] lim;
    } frame_ctl_t;

    function automatic int unsigned rj_len(input logic [1:0] sel);
        case (sel)
            2'd1:    return 20;
            2'd2:    return 16;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/srx_sync_edge.sv
module srx_sync_edge
    import srx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bclk_i,
    input  logic        fclk_i,
    input  logic        sdata_i,
    output serial_evt_t evt_o
);

    logic [STAGES-1:0][2:0] stage_q;
    logic                   bclk_prev_q;
    logic [2:0]             line_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q     <= '0;
            bclk_prev_q <= 1'b0;
        end else begin
            stage_q[0] <= {bclk_i, fclk_i, sdata_i};
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
            bclk_prev_q <= stage_q[STAGES-1][2];
        end
    end

    assign line_s = stage_q[STAGES-1];

    always_comb begin
        evt_o.rise  = line_s[2] & ~bclk_prev_q;
        evt_o.fall  = ~line_s[2] & bclk_prev_q;
        evt_o.fclk  = line_s[1];
        evt_o.sdata = line_s[0];
    end

endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int HALF_SLOTS = 32,
    parameter int POS_W      = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  serial_evt_t evt_i,
    input  fmt_e        fmt_i,
    input  logic [1:0]  wlen_i,
    input  logic        packed_i,
    output frame_ctl_t  ctl_o
);

    logic             f1_q, f2_q;
    logic [1:0]       hist_q;
    logic [POS_W-1:0] pos_q;
    logic             active_q;
    chan_e            dsp_ch_q;
    logic             dsp_seen_q;

    logic             is_dsp, is_i2s, rj_eff, smp;
    logic             feff_now, feff_prev;
    logic             bnd;
    chan_e            new_ch;
    logic [POS_W-1:0] pos_now, start_pos;

    always_comb begin
        is_dsp    = (fmt_i == FMT_DSP);
        is_i2s    = (fmt_i == FMT_I2S);
        rj_eff    = (fmt_i == FMT_RJ) && !packed_i;
        smp       = is_dsp ? evt_i.fall : evt_i.rise;
        // I2S behaves as left-justified on a frame clock delayed by one bit
        feff_now  = is_i2s ? ~f1_q : evt_i.fclk;
        feff_prev = is_i2s ? ~f2_q : f1_q;
        start_pos = rj_eff ? POS_W'(HALF_SLOTS - int'(rj_len(wlen_i))) : '0;

        if (is_dsp) begin
            bnd    = smp && evt_i.fclk && !f1_q;
            new_ch = (dsp_seen_q && dsp_ch_q == CH_LEFT) ? CH_RIGHT : CH_LEFT;
        end else begin
            bnd    = smp && (hist_q == 2'd2) && (feff_now != feff_prev);
            new_ch = feff_now ? CH_LEFT : CH_RIGHT;
        end

        pos_now = bnd ? '0 : pos_q;

        ctl_o.bnd    = bnd;
        ctl_o.new_ch = new_ch;
        ctl_o.dbit   = evt_i.sdata;
        ctl_o.lim    = rj_eff ? CNT_W'(rj_len(wlen_i)) : CNT_W'(WORD_W);
        if (is_dsp) begin
            ctl_o.cap = smp && !evt_i.fclk && (active_q || bnd);
        end else begin
            ctl_o.cap = smp && (active_q || bnd) && (pos_now >= start_pos);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f1_q       <= 1'b0;
            f2_q       <= 1'b0;
            hist_q     <= '0;
            pos_q      <= '0;
            active_q   <= 1'b0;
            dsp_ch_q   <= CH_LEFT;
            dsp_seen_q <= 1'b0;
        end else if (smp) begin
            f1_q <= evt_i.fclk;
            f2_q <= f1_q;
            if (hist_q != 2'd2) begin
                hist_q <= hist_q + 2'd1;
            end
            if (pos_now != '1) begin
                pos_q <= pos_now + 1'b1;
            end else begin
                pos_q <= pos_now;
            end
            if (bnd) begin
                active_q <= 1'b1;
            end
            if (is_dsp && bnd) begin
                dsp_ch_q   <= new_ch;
                dsp_seen_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/srx_assembler.sv
module srx_assembler
    import srx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  frame_ctl_t        ctl_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o
);

    logic [WORD_W-1:0] acc_q, left_hold_q;
    logic [CNT_W-1:0]  cnt_q;
    chan_e             cur_q;
    logic              have_cur_q, left_ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q       <= '0;
            left_hold_q <= '0;
            cnt_q       <= '0;
            cur_q       <= CH_LEFT;
            have_cur_q  <= 1'b0;
            left_ok_q   <= 1'b0;
            left_o      <= '0;
            right_o     <= '0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (ctl_i.bnd) begin
                // close the word of the channel that just ended
                if (have_cur_q) begin
                    if (cur_q == CH_LEFT) begin
                        left_hold_q <= acc_q;
                        left_ok_q   <= 1'b1;
                    end else if (left_ok_q) begin
                        left_o    <= left_hold_q;
                        right_o   <= acc_q;
                        valid_o   <= 1'b1;
                        left_ok_q <= 1'b0;
                    end
                end
                acc_q      <= '0;
                cnt_q      <= '0;
                cur_q      <= ctl_i.new_ch;
                have_cur_q <= 1'b1;
                if (ctl_i.cap) begin
                    acc_q[WORD_W-1] <= ctl_i.dbit;
                    cnt_q           <= CNT_W'(1);
                end
            end else if (ctl_i.cap && have_cur_q && (cnt_q < ctl_i.lim)) begin
                acc_q[(WORD_W-1) - int'(cnt_q)] <= ctl_i.dbit;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
    import srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HALF_SLOTS  = 32,
    parameter int POS_W       = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk_i,
    input  logic              fclk_i,
    input  logic              sdata_i,
    input  logic [1:0]        fmt_i,
    input  logic [1:0]        wlen_i,
    input  logic              packed_i,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o
);

    serial_evt_t evt;
    frame_ctl_t  ctl;

    srx_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk     (clk),
        .rst     (rst),
        .bclk_i  (bclk_i),
        .fclk_i  (fclk_i),
        .sdata_i (sdata_i),
        .evt_o   (evt)
    );

    srx_framer #(
        .HALF_SLOTS (HALF_SLOTS),
        .POS_W      (POS_W)
    ) framer_i (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .fmt_i    (fmt_e'(fmt_i)),
        .wlen_i   (wlen_i),
        .packed_i (packed_i),
        .ctl_o    (ctl)
    );

    srx_assembler asm_i (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (ctl),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

endmodule

// File: rtl/stereo_serial_rx_chk.sv
module stereo_serial_rx_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  fmt_i,
    input logic [1:0]  wlen_i,
    input logic        packed_i,
    input logic [23:0] left_o,
    input logic [23:0] right_o,
    input logic        valid_o
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) rst |=> !valid_o);

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R10
    left_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (left_o != $past(left_o)) |-> valid_o);

    // R10
    right_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (right_o != $past(right_o)) |-> valid_o);

    // R8
    rj16_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && fmt_i == 2'd0 && wlen_i == 2'd2 && !packed_i)
        |-> (left_o[7:0] == 8'h00 && right_o[7:0] == 8'h00));

endmodule

bind stereo_serial_rx stereo_serial_rx_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .fmt_i    (fmt_i),
    .wlen_i   (wlen_i),
    .packed_i (packed_i),
    .left_o   (left_o),
    .right_o  (right_o),
    .valid_o  (valid_o)
);

// File: tb/stereo_serial_rx_tb.sv
module stereo_serial_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk = 1'b0, fclk = 1'b0, sdata = 1'b0;
    logic [1:0]  fmt = 2'd2, wlen = 2'd0;
    logic        pk = 1'b0;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int checks = 0;
    int errors = 0;

    logic [31:0] lv [16];
    logic [31:0] rv [16];
    logic [23:0] rx_l [16];
    logic [23:0] rx_r [16];
    int          rx_n = 0;
    logic        prev_v = 1'b0;
    logic        dbl = 1'b0;

    always #5 clk = ~clk;

    stereo_serial_rx dut_i (
        .clk      (clk),
        .rst      (rst),
        .bclk_i   (bclk),
        .fclk_i   (fclk),
        .sdata_i  (sdata),
        .fmt_i    (fmt),
        .wlen_i   (wlen),
        .packed_i (pk),
        .left_o   (left_o),
        .right_o  (right_o),
        .valid_o  (valid_o)
    );

    always @(negedge clk) begin
        if (valid_o && prev_v) dbl <= 1'b1;
        prev_v <= valid_o;
        if (valid_o && rx_n < 16) begin
            rx_l[rx_n] <= left_o;
            rx_r[rx_n] <= right_o;
            rx_n <= rx_n + 1;
        end
    end

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic word_bit(input logic [31:0] v, input int w, input int idx);
        if (idx >= 0 && idx < w) return v[w-1-idx];
        return 1'b0;
    endfunction

    function automatic logic [23:0] exp_word(input logic [31:0] v, input int w);
        logic [31:0] t;
        if (w >= 24) t = v >> (w - 24);
        else         t = v << (24 - w);
        return t[23:0];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bclk = 1'b0; fclk = 1'b0; sdata = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        rx_n = 0;
        dbl = 1'b0;
    endtask

    task automatic drive_slot(input logic fc, input logic d, input logic dsp);
        bclk = dsp; fclk = fc; sdata = d;
        repeat (4) @(negedge clk);
        bclk = ~dsp;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_stream(input int w, input int h, input int nfr);
        logic prev_lj = 1'b0;
        for (int f = 0; f < nfr + 2; f++) begin
            for (int hh = 0; hh < 2; hh++) begin
                logic [31:0] val;
                val = (hh == 0) ? lv[f] : rv[f];
                for (int j = 0; j < h; j++) begin
                    logic ljb, fc, d;
                    int   s;
                    ljb = word_bit(val, w, j);
                    s   = 32 - w;
                    case (fmt)
                        2'd0: begin
                            fc = (hh == 0);
                            if (pk) d = ljb;
                            else    d = (j < s) ? 1'b1 : word_bit(val, w, j - s);
                        end
                        2'd1: begin
                            fc = (hh == 1);
                            d  = prev_lj;
                        end
                        2'd3: begin
                            fc = (j == 0);
                            d  = word_bit(val, w, j - 1);
                        end
                        default: begin
                            fc = (hh == 0);
                            d  = ljb;
                        end
                    endcase
                    prev_lj = ljb;
                    drive_slot(fc, d, fmt == 2'd3);
                end
            end
        end
        bclk = 1'b0; fclk = 1'b0; sdata = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic run_case(input string tag, input logic [1:0] f, input logic [1:0] wl,
                            input logic p, input int w, input int h, input int n,
                            input logic [31:0] seed);
        logic [31:0] mask;
        int expn;
        fmt = f; wlen = wl; pk = p;
        mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        for (int k = 0; k < n + 2; k++) begin
            lv[k] = (seed ^ (32'(k) * 32'h9E37_79B1)) & mask;
            rv[k] = ((seed * 32'h0001_0DCD) + 32'(k) * 32'h7F4A_7C15) & mask;
        end
        do_reset();
        send_stream(w, h, n);
        expn = n + ((f == 2'd3) ? 1 : 0);
        check(rx_n == expn, tag, "pair count", 32'(rx_n), 32'(expn));
        for (int k = 0; k < n; k++) begin
            int idx;
            idx = rx_n - n + k;
            if (idx >= 0 && idx < 16) begin
                check(rx_l[idx] == exp_word(lv[k+1], w), tag, "left word",
                      32'(rx_l[idx]), 32'(exp_word(lv[k+1], w)));
                check(rx_r[idx] == exp_word(rv[k+1], w), tag, "right word",
                      32'(rx_r[idx]), 32'(exp_word(rv[k+1], w)));
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0, "R1", "valid in reset", 32'(valid_o), 0);
        check(left_o == '0 && right_o == '0, "R1", "outputs in reset",
              {8'h0, left_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(valid_o == 1'b0, "R1", "valid after reset", 32'(valid_o), 0);
    endtask

    task automatic t_hold();
        logic [23:0] l0, r0;
        run_case("R10 strobe", 2'd2, 2'd0, 1'b0, 24, 32, 2, 32'h1357_9BDF);
        check(dbl == 1'b0, "R10", "strobe width above one cycle", 32'(dbl), 0);
        l0 = left_o; r0 = right_o;
        repeat (60) @(negedge clk);
        check(left_o == l0 && right_o == r0 && !valid_o, "R10", "outputs held",
              {8'h0, left_o}, {8'h0, l0});
    endtask

    initial begin
        t_reset();
        run_case("R2 left-justified tight", 2'd2, 2'd0, 1'b0, 24, 24, 3, 32'hA5C3_0F11);
        run_case("R3 I2S tight",            2'd1, 2'd0, 1'b0, 24, 24, 3, 32'h5E21_77A0);
        run_case("R3 R8 I2S 16-bit",        2'd1, 2'd0, 1'b0, 16, 32, 3, 32'h0BAD_CAFE);
        run_case("R4 right-justified 24",   2'd0, 2'd0, 1'b0, 24, 32, 3, 32'h1234_5678);
        run_case("R4 right-justified 20",   2'd0, 2'd1, 1'b0, 20, 32, 3, 32'h8765_4321);
        run_case("R4 R8 right-justified 16",2'd0, 2'd2, 1'b0, 16, 32, 3, 32'hDEAD_BEEF);
        run_case("R5 right-justified long", 2'd0, 2'd0, 1'b0, 24, 48, 3, 32'h7777_1111);
        run_case("R6 R8 DSP 20-bit",        2'd3, 2'd0, 1'b0, 20, 32, 3, 32'h2468_ACE0);
        run_case("R7 left-justified 28-bit",2'd2, 2'd0, 1'b0, 28, 32, 3, 32'hF0E1_D2C3);
        run_case("R9 packed",               2'd0, 2'd0, 1'b1, 16, 16, 3, 32'h3C3C_5A5A);
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule